// File: doc/BRIEF.md
# Macro-Block Raster Fetch Address Generator

This block produces the read addresses for every pixel of a rectangular macro-block held inside a larger image slice. The slice is stored row after row, and its width in pixels is the row pitch. After a start pulse loads the base offset, the block width, the block height and the slice pitch, the generator gives one address per clock while its enable input is high. It walks the block left to right, then top to bottom.

Inside a row the address moves up by one. At the end of a row a single shared adder applies a precomputed correction of pitch minus block width plus one. This lands the address on the first pixel of the next block row. Two counters track the column and the row, and each one ends when it matches its limit. After the last pixel the done flag rises and the address holds until the next start.

A motion-estimation datapath uses one instance for the current block and a second instance for the reference block.

Top module: `mb_fetch_agu`

## Requirements
- R1: While reset is low, and in the first cycle after it, done reads 1 and addr reads 0.
- R2: A start pulse wins over enable. In the cycle after start, addr equals base_addr and done is 0.
- R3: Inside a block row, each clock with enable high and done low raises addr by exactly 1 in the next cycle.
- R4: At the last column of a row that is not the last row, an enabled clock moves addr to base_addr + (row+1) × slice_w, so addr rises by slice_w − blk_w + 1.
- R5: With enable low, addr and done keep their values.
- R6: The block emits exactly blk_w × blk_h addresses, equal to base_addr + y × slice_w + x in raster order. After the last of them is consumed, done is 1 and addr holds that last address until the next start, even if enable stays high.
- R7: A block width of 1 makes every step a row jump. A block height of 1 finishes after blk_w addresses.
- R8: All address arithmetic wraps modulo 2^ADDR_W.
- R9: A start pulse while a block is only partly walked restarts the walk from the new base, using the new sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Loads the configuration and restarts the walk |
| enable | input | 1 | Consumes the current address and advances to the next |
| base_addr | input | ADDR_W (16) | Offset of the block's top-left pixel |
| blk_w | input | DIM_W (8) | Block width in pixels, at least 1 |
| blk_h | input | DIM_W (8) | Block height in rows, at least 1 |
| slice_w | input | PITCH_W (12) | Slice row pitch, at least blk_w |
| addr | output | ADDR_W (16) | Current fetch address |
| done | output | 1 | Every address of the block has been consumed |

## Verification
The bench walks blocks that are square, tall and thin, wide and flat, and single-pixel. It also walks a block whose pitch equals its width and a block that runs past the top of the address space. It compares every address with base plus row times pitch plus column.

A design with an off-by-one correction would drift by one pixel per row. A design with a late row comparator would emit one extra pixel per row. A design that stopped one address early or one address late would fail the done check. Random enable gaps catch a design that advances without enable. A restart in the middle of a block catches counters that are not cleared.

// File: rtl/mb_agu_pkg.sv
// Package: shared types for the macro-block fetch address generator.
// Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package mb_agu_pkg;

    // Which increment the shared adder applies in a given cycle.
    typedef enum logic {
        STEP_PIXEL = 1'b0,   // next pixel in the same row
        STEP_ROW   = 1'b1    // jump to the first pixel of the next row
    } step_sel_e;

endpackage

// File: rtl/mb_cfg_latch.sv
// Module: mb_cfg_latch
// Captures the block sizes at start and derives the row-end correction
// (pitch - width + 1) once, so the per-cycle path holds only one adder.
// Assumes slice_w >= blk_w and blk_w >= 1; other values are not checked.
module mb_cfg_latch #(
    parameter int ADDR_W  = 16,
    parameter int DIM_W   = 8,
    parameter int PITCH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DIM_W-1:0]   blk_w,
    input  logic [DIM_W-1:0]   blk_h,
    input  logic [PITCH_W-1:0] slice_w,
    output logic [DIM_W-1:0]   w_q,
    output logic [DIM_W-1:0]   h_q,
    output logic [ADDR_W-1:0]  jump_q
);
    localparam int SUM_W = (ADDR_W > PITCH_W) ? ADDR_W : PITCH_W;

    logic [SUM_W-1:0] jump_d;

    // Row-end correction computed from the raw inputs at load time.
    always_comb begin
        jump_d = SUM_W'(slice_w) - SUM_W'(blk_w) + SUM_W'(1);
    end

    // Hold the configuration from one start to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= '0;
            h_q    <= '0;
            jump_q <= '0;
        end else if (load) begin
            w_q    <= blk_w;
            h_q    <= blk_h;
            jump_q <= ADDR_W'(jump_d);
        end
    end
endmodule

// File: rtl/mb_axis_counter.sv
// Module: mb_axis_counter
// Counts positions along one axis from 0 to limit-1 and wraps to 0.
// at_last flags the final position by comparison with the limit.
// Assumes limit >= 1 whenever adv is used; clear takes priority over adv.
module mb_axis_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    // Terminal compare against the loaded size.
    always_comb begin
        at_last = (cnt == (limit - W'(1)));
    end

    // Step the position, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_last ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/mb_step_adder.sv
// Module: mb_step_adder
// The single adder shared by both step kinds. It adds 1 inside a row and
// the stored correction at a row end. The sum wraps modulo 2^ADDR_W.
module mb_step_adder #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]    cur,
    input  logic [ADDR_W-1:0]    jump,
    input  mb_agu_pkg::step_sel_e sel,
    output logic [ADDR_W-1:0]    nxt
);
    import mb_agu_pkg::*;

    logic [ADDR_W-1:0] inc;

    // Pick the increment, then add it through one carry chain.
    always_comb begin
        inc = (sel == STEP_ROW) ? jump : ADDR_W'(1);
        nxt = cur + inc;
    end
endmodule

// File: rtl/mb_fetch_agu.sv
// Module: mb_fetch_agu (top)
// Walks a blk_w x blk_h macro-block in raster order inside a slice of
// row pitch slice_w. It gives one address per enabled clock and raises
// done after the last one.
// Assumes blk_w >= 1, blk_h >= 1 and slice_w >= blk_w at start.
// addr is meaningful while done is low after a start.
module mb_fetch_agu #(
    parameter int ADDR_W  = 16,
    parameter int DIM_W   = 8,
    parameter int PITCH_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [DIM_W-1:0]   blk_w,
    input  logic [DIM_W-1:0]   blk_h,
    input  logic [PITCH_W-1:0] slice_w,
    output logic [ADDR_W-1:0]  addr,
    output logic               done
);
    import mb_agu_pkg::*;

    logic [DIM_W-1:0]  w_q, h_q;
    logic [ADDR_W-1:0] jump_q;
    logic [DIM_W-1:0]  x_cnt, y_cnt;
    logic              x_last, y_last;
    logic              adv_x, adv_y, finishing;
    step_sel_e         sel;
    logic [ADDR_W-1:0] offset_q, offset_nxt;
    logic              done_q;

    // Advance decode: a start pulse blocks any step in its cycle.
    always_comb begin
        adv_x     = enable && !done_q && !start;
        adv_y     = adv_x && x_last;
        finishing = adv_y && y_last;
        sel       = x_last ? STEP_ROW : STEP_PIXEL;
    end

    mb_cfg_latch #(
        .ADDR_W  (ADDR_W),
        .DIM_W   (DIM_W),
        .PITCH_W (PITCH_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .blk_w   (blk_w),
        .blk_h   (blk_h),
        .slice_w (slice_w),
        .w_q     (w_q),
        .h_q     (h_q),
        .jump_q  (jump_q)
    );

    mb_axis_counter #(.W(DIM_W)) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .adv     (adv_x),
        .limit   (w_q),
        .cnt     (x_cnt),
        .at_last (x_last)
    );

    mb_axis_counter #(.W(DIM_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .adv     (adv_y),
        .limit   (h_q),
        .cnt     (y_cnt),
        .at_last (y_last)
    );

    mb_step_adder #(.ADDR_W(ADDR_W)) u_add (
        .cur  (offset_q),
        .jump (jump_q),
        .sel  (sel),
        .nxt  (offset_nxt)
    );

    // Offset register: load on start, step on an enabled clock, hold at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= '0;
        end else if (start) begin
            offset_q <= base_addr;
        end else if (adv_x && !finishing) begin
            offset_q <= offset_nxt;
        end
    end

    // Done flag: set in reset and after the last pixel, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else if (start) begin
            done_q <= 1'b0;
        end else if (finishing) begin
            done_q <= 1'b1;
        end
    end

    // Drive the outputs straight from the registers.
    always_comb begin
        addr = offset_q;
        done = done_q;
    end
endmodule

// File: rtl/mb_fetch_agu_chk.sv
// Module: mb_fetch_agu_chk
// Assertion checker bound into mb_fetch_agu. It keeps its own copy of the
// row correction so that the step checks do not reuse the design's adder.
module mb_fetch_agu_chk #(
    parameter int ADDR_W  = 16,
    parameter int DIM_W   = 8,
    parameter int PITCH_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               enable,
    input logic [ADDR_W-1:0]  base_addr,
    input logic [DIM_W-1:0]   blk_w,
    input logic [PITCH_W-1:0] slice_w,
    input logic [ADDR_W-1:0]  addr,
    input logic               done,
    input logic               x_last,
    input logic               y_last
);
    logic [ADDR_W-1:0] exp_jump;

    // Checker-side copy of pitch - width + 1, taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_jump <= '0;
        else if (start) exp_jump <= ADDR_W'(slice_w) - ADDR_W'(blk_w) + ADDR_W'(1);
    end

    // R2: start loads the base and clears done
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr == $past(base_addr)) && !done);

    // R3: step by one inside a row
    p_pixel_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !done && !start && !x_last) |=> addr == $past(addr) + ADDR_W'(1));

    // R4: row jump at a row end that is not the last row
    p_row_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !done && !start && x_last && !y_last) |=> addr == $past(addr) + exp_jump);

    // R5: no movement without enable
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !start) |=> $stable(addr) && $stable(done));

    // R6: done holds the address until the next start
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(addr));

    // R6: done rises only after the last column of the last row
    p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(enable && x_last && y_last));
endmodule

bind mb_fetch_agu mb_fetch_agu_chk #(
    .ADDR_W  (ADDR_W),
    .DIM_W   (DIM_W),
    .PITCH_W (PITCH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .enable    (enable),
    .base_addr (base_addr),
    .blk_w     (blk_w),
    .slice_w   (slice_w),
    .addr      (addr),
    .done      (done),
    .x_last    (x_last),
    .y_last    (y_last)
);

// File: tb/tb_mb_fetch_agu.sv
// Bench for mb_fetch_agu: sweeps block shapes and computes every expected
// address as base + y*pitch + x modulo 2^16.
module tb_mb_fetch_agu;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int PW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          enable = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [DW-1:0] blk_w = '0;
    logic [DW-1:0] blk_h = '0;
    logic [PW-1:0] slice_w = '0;
    logic [AW-1:0] addr;
    logic          done;

    int total = 0;
    int bad = 0;
    int gap_seed = 7;

    mb_fetch_agu #(.ADDR_W(AW), .DIM_W(DW), .PITCH_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
        .base_addr(base_addr), .blk_w(blk_w), .blk_h(blk_h),
        .slice_w(slice_w), .addr(addr), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check result and report a mismatch.
    task automatic check(input bit ok, input string req,
                         input logic [AW-1:0] act_a, input logic act_d,
                         input logic [AW-1:0] exp_a, input logic exp_d);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: addr=%h done=%0b expected addr=%h done=%0b",
                     req, act_a, act_d, exp_a, exp_d);
        end
    endtask

    // Pulse start together with enable (start must win), then walk the block.
    // stop_after < 0 walks it fully; otherwise stop after that many addresses.
    task automatic run_block(input logic [AW-1:0] b, input int w, input int h,
                             input int p, input bit gaps, input int stop_after);
        logic [AW-1:0] e;
        logic [AW-1:0] last;
        @(negedge clk);
        start = 1'b1; enable = 1'b1;
        base_addr = b; blk_w = DW'(w); blk_h = DW'(h); slice_w = PW'(p);
        @(negedge clk);
        start = 1'b0;
        check(addr == b && !done, "R2", addr, done, b, 1'b0);
        last = b;
        for (int idx = 0; idx < w*h; idx++) begin
            int y;
            int x;
            if (stop_after >= 0 && idx == stop_after) begin
                enable = 1'b0;
                return;
            end
            y = idx / w;
            x = idx % w;
            e = b + AW'(y*p + x);
            last = e;
            if (x == 0 && y > 0)
                check(addr == e && !done, (w == 1) ? "R4 R7" : "R4", addr, done, e, 1'b0);
            else
                check(addr == e && !done, (h == 1) ? "R3 R7" : "R3", addr, done, e, 1'b0);
            gap_seed = (gap_seed * 1103515245 + 12345) & 32'h7fffffff;
            if (gaps && (gap_seed % 3 == 0)) begin
                enable = 1'b0;
                @(negedge clk);
                check(addr == e && !done, "R5", addr, done, e, 1'b0);
                enable = 1'b1;
            end
            @(negedge clk);
        end
        check(addr == last && done, "R6", addr, done, last, 1'b1);
        @(negedge clk);
        check(addr == last && done, "R6", addr, done, last, 1'b1);
        enable = 1'b0;
        @(negedge clk);
        check(addr == last && done, "R6", addr, done, last, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(addr == '0 && done, "R1", addr, done, '0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr == '0 && done, "R1", addr, done, '0, 1'b1);

        run_block(16'h0100, 4, 4, 4, 1'b0, -1);     // pitch equals width
        run_block(16'h0200, 3, 5, 10, 1'b0, -1);
        run_block(16'h0050, 8, 8, 32, 1'b1, -1);    // random enable gaps
        run_block(16'h0007, 1, 1, 1, 1'b0, -1);     // R7 single pixel
        run_block(16'h0300, 1, 5, 7, 1'b0, -1);     // R7 width 1
        run_block(16'h0400, 6, 1, 9, 1'b1, -1);     // R7 height 1
        run_block(16'hFFF0, 4, 3, 16, 1'b0, -1);    // R8 wraps past 0xFFFF
        run_block(16'h0500, 4, 4, 10, 1'b0, 5);     // R9 partial walk...
        run_block(16'h0A00, 5, 3, 12, 1'b1, -1);    // R9 ...then restart
        for (int w = 1; w <= 4; w++)
            for (int h = 1; h <= 3; h++)
                run_block(AW'(w*256 + h*16), w, h, w + h, 1'b0, -1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule